// File: doc/BRIEF.md
# CAN Node Bus-Integration Controller

This block decides when a CAN protocol node may drive and take part in bus traffic. It samples the receive line on each bit-time strobe and counts runs of consecutive recessive bits. It uses those runs for two things: to let an idle node join the bus, and to bring a node back out of the bus-off state. Bit timing, framing, arbitration, CRC and error counting belong to neighbouring units. This block sees only their results: a sampled bit with its strobe, a bus-off entry pulse and a bus-idle indication.

Software owns an init control bit. The bit resets to 1 and is written through a simple write strobe. A debug suspend request, when its enable is set, can also hold the node inactive. It does this through an internal term and never changes the visible init bit. Bus-off recovery runs on its own, whatever the init bit is. All interfaces are plain level or pulse control pins. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `can_bus_integ`

## Requirements
- R1: While the synchronous reset is high and on the first sample after it, init_bit is 1, node_active is 0, bus_off is 0, tx_recessive is 1 and frame_abort is 0.
- R2: Writing 1 to the init bit while the node is active gives a frame_abort pulse and holds tx_recessive at 1 in the first cycle that init_bit reads 1. node_active is 0 one cycle later.
- R3: With the init bit cleared and the node not bus-off, node_active rises on the clock edge that samples the 11th consecutive recessive bit (rx_bit = 1 with bit_tick = 1). After only 10 such bits it stays 0.
- R4: A dominant bit (rx_bit = 0 with bit_tick = 1) restarts the recessive run from zero. Cycles without bit_tick do not count.
- R5: A bus-off entry pulse sets bus_off and clears node_active at the next clock edge, whatever the init bit is.
- R6: bus_off clears on the edge that completes the 128th run of 11 consecutive recessive bits after entry, and not before.
- R7: Writing the init bit during bus-off neither stops nor restarts the recovery count.
- R8: If the effective init is 1 when recovery completes, bus_off clears but node_active stays 0. Once init is cleared, 11 fresh recessive bits are needed to become active.
- R9: If the effective init is 0 when recovery completes, node_active rises on the same edge at which bus_off falls.
- R10: With suspend enabled, a suspend request takes effect once bus_idle is high or the node is bus-off. The node then goes inactive while init_bit keeps its value. After the request is removed, 11 recessive bits are needed to rejoin.
- R11: With suspend disabled, a suspend request has no effect on node_active or tx_recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe marking a valid sampled bit |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| init_we | input | 1 | Write strobe for the init control bit |
| init_wdata | input | 1 | Value written to the init bit when init_we is high |
| boff_enter | input | 1 | Pulse from the error-counter unit: enter bus-off |
| susp_req | input | 1 | Debug suspend request |
| susp_en | input | 1 | Enables the suspend request |
| bus_idle | input | 1 | Bus is idle (no frame in progress) |
| init_bit | output | 1 | Software-visible init control bit |
| node_active | output | 1 | Registered: node takes part in bus traffic |
| bus_off | output | 1 | Registered: node is in bus-off |
| tx_recessive | output | 1 | Forces the transmit line recessive |
| frame_abort | output | 1 | One-cycle pulse: frame in progress is cancelled |

## Verification
node_active and bus_off are registered. They change on the edge that samples the completing strobe, or the edge after a bus-off pulse or an init write. init_bit changes on the edge that takes the write. frame_abort and tx_recessive follow that registered bit in the same cycle. A suspend takes two edges: one to latch it and one to drop node_active. The bench drives inputs on falling edges and keeps a behavioural model that is updated on every rising edge. It compares all five outputs against that model on every falling edge. Directed checks sample at the cycle where each result becomes due.

// File: rtl/can_integ_pkg.sv
package can_integ_pkg;
  // Recessive bits that make up one idle run on the bus
  localparam int unsigned RUN_LEN_DEF  = 11;
  // Idle runs needed to leave bus-off
  localparam int unsigned REC_RUNS_DEF = 128;

  typedef enum logic [1:0] {
    NS_WAIT = 2'd0,   // not participating
    NS_ON   = 2'd1,   // participating
    NS_BOFF = 2'd2    // bus-off recovery in progress
  } node_st_e;
endpackage

// File: rtl/can_run_det.sv
module can_run_det #(
  parameter int unsigned RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_tick,
  input  logic rx_bit,
  output logic run_done
);
  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign run_done = bit_tick && rx_bit && (cnt_q == RUN_MAX) && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (bit_tick) begin
      if (!rx_bit || cnt_q == RUN_MAX) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  dominant_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !rx_bit) |=> (cnt_q == '0));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/can_rec_cnt.sv
module can_rec_cnt #(
  parameter int unsigned REC_RUNS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned RW = (REC_RUNS > 1) ? $clog2(REC_RUNS) : 1;
  localparam logic [RW-1:0] REC_MAX = RW'(REC_RUNS - 1);

  logic [RW-1:0] cnt_q;

  assign last = (cnt_q == REC_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (inc)    cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  // R7
  rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/can_init_gate.sv
module can_init_gate (
  input  logic clk,
  input  logic rst,
  input  logic init_we,
  input  logic init_wdata,
  input  logic susp_req,
  input  logic susp_en,
  input  logic bus_idle,
  input  logic in_boff,
  output logic init_bit,
  output logic eff_init
);
  logic init_q;
  logic susp_q;
  logic susp_arm;

  assign susp_arm = susp_en && susp_req;

  always_ff @(posedge clk) begin
    if (rst)          init_q <= 1'b1;
    else if (init_we) init_q <= init_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || !susp_arm) susp_q <= 1'b0;
    else if (bus_idle || in_boff) susp_q <= 1'b1;
  end

  assign init_bit = init_q;
  assign eff_init = init_q || susp_q;

  // R11
  susp_off_chk: assert property (@(posedge clk) disable iff (rst)
    !susp_en |=> !susp_q);

  // R10
  susp_keeps_init_chk: assert property (@(posedge clk) disable iff (rst)
    (!init_we && susp_arm) |=> $stable(init_q));
endmodule

// File: rtl/can_bus_integ.sv
module can_bus_integ
  import can_integ_pkg::*;
#(
  parameter int unsigned RUN_LEN  = RUN_LEN_DEF,
  parameter int unsigned REC_RUNS = REC_RUNS_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic init_we,
  input  logic init_wdata,
  input  logic boff_enter,
  input  logic susp_req,
  input  logic susp_en,
  input  logic bus_idle,
  output logic init_bit,
  output logic node_active,
  output logic bus_off,
  output logic tx_recessive,
  output logic frame_abort
);
  node_st_e st_q, st_d;
  logic     eff_init;
  logic     run_done;
  logic     rec_last;
  logic     in_boff;
  logic     run_clr;
  logic     rec_clr;
  logic     rec_inc;

  assign in_boff = (st_q == NS_BOFF);
  assign run_clr = boff_enter || (eff_init && !in_boff);
  assign rec_clr = boff_enter || !in_boff;
  assign rec_inc = in_boff && run_done;

  can_init_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .init_we    (init_we),
    .init_wdata (init_wdata),
    .susp_req   (susp_req),
    .susp_en    (susp_en),
    .bus_idle   (bus_idle),
    .in_boff    (in_boff),
    .init_bit   (init_bit),
    .eff_init   (eff_init)
  );

  can_run_det #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst      (rst),
    .clr      (run_clr),
    .bit_tick (bit_tick),
    .rx_bit   (rx_bit),
    .run_done (run_done)
  );

  can_rec_cnt #(.REC_RUNS(REC_RUNS)) u_rec (
    .clk  (clk),
    .rst  (rst),
    .clr  (rec_clr),
    .inc  (rec_inc),
    .last (rec_last)
  );

  always_comb begin
    st_d = st_q;
    if (boff_enter) begin
      st_d = NS_BOFF;
    end else begin
      unique case (st_q)
        NS_BOFF: if (run_done && rec_last) st_d = eff_init ? NS_WAIT : NS_ON;
        NS_WAIT: if (!eff_init && run_done) st_d = NS_ON;
        NS_ON:   if (eff_init) st_d = NS_WAIT;
        default: st_d = NS_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= NS_WAIT;
    else     st_q <= st_d;
  end

  assign node_active  = (st_q == NS_ON);
  assign bus_off      = in_boff;
  assign tx_recessive = !node_active || eff_init;
  assign frame_abort  = node_active && eff_init;

  // R2
  init_drops_chk: assert property (@(posedge clk) disable iff (rst)
    eff_init |=> !node_active);

  // R5
  boff_entry_chk: assert property (@(posedge clk) disable iff (rst)
    boff_enter |=> (bus_off && !node_active));

  // R6
  boff_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_off) |-> $past(run_done && !boff_enter));

  // R8
  exit_inactive_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_off) && $past(eff_init)) |-> !node_active);

  // R9
  exit_active_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_off) && !$past(eff_init)) |-> node_active);

  // R3
  join_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(node_active) && !$past(bus_off)) |-> $past(run_done));
endmodule

// File: tb/tb_can_bus_integ.sv
module tb_can_bus_integ;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, rx_bit = 1'b1;
  logic init_we = 1'b0, init_wdata = 1'b0;
  logic boff_enter = 1'b0;
  logic susp_req = 1'b0, susp_en = 1'b0, bus_idle = 1'b0;
  logic init_bit, node_active, bus_off, tx_recessive, frame_abort;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  can_bus_integ dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .init_we(init_we), .init_wdata(init_wdata), .boff_enter(boff_enter),
    .susp_req(susp_req), .susp_en(susp_en), .bus_idle(bus_idle),
    .init_bit(init_bit), .node_active(node_active), .bus_off(bus_off),
    .tx_recessive(tx_recessive), .frame_abort(frame_abort)
  );

  // Behavioural reference: integers, updated once per rising edge
  int m_init, m_susp, m_run, m_rec, m_boff, m_act;

  always @(posedge clk) begin
    int eff, done, n_boff, n_act, n_rec, n_run, n_susp;
    if (rst) begin
      m_init = 1; m_susp = 0; m_run = 0; m_rec = 0; m_boff = 0; m_act = 0;
    end else begin
      eff  = (m_init != 0 || m_susp != 0) ? 1 : 0;
      done = (bit_tick && rx_bit && m_run == 10) ? 1 : 0;
      n_boff = m_boff; n_act = m_act; n_rec = m_rec;
      if (boff_enter || (eff != 0 && m_boff == 0)) n_run = 0;
      else if (bit_tick) n_run = (rx_bit && m_run < 10) ? m_run + 1 : 0;
      else n_run = m_run;
      if (boff_enter) begin
        n_boff = 1; n_act = 0; n_rec = 0;
      end else if (m_boff != 0) begin
        if (done != 0) begin
          if (m_rec == 127) begin n_boff = 0; n_rec = 0; n_act = (eff != 0) ? 0 : 1; end
          else n_rec = m_rec + 1;
        end
      end else if (eff != 0) n_act = 0;
      else if (m_act == 0 && done != 0) n_act = 1;
      if (susp_en && susp_req) n_susp = (m_susp != 0 || bus_idle || m_boff != 0) ? 1 : 0;
      else n_susp = 0;
      if (init_we) m_init = init_wdata ? 1 : 0;
      m_susp = n_susp; m_run = n_run; m_rec = n_rec; m_boff = n_boff; m_act = n_act;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      int eff;
      eff = (m_init != 0 || m_susp != 0) ? 1 : 0;
      chk("R1", "init_bit", int'(init_bit), m_init);
      chk("R3", "node_active", int'(node_active), m_act);
      chk("R6", "bus_off", int'(bus_off), m_boff);
      chk("R2", "tx_recessive", int'(tx_recessive), (m_act == 0 || eff != 0) ? 1 : 0);
      chk("R2", "frame_abort", int'(frame_abort), (m_act != 0 && eff != 0) ? 1 : 0);
    end
  end

  task automatic send_bit(input logic v);
    bit_tick = 1'b1; rx_bit = v;
    @(negedge clk);
    bit_tick = 1'b0; rx_bit = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_rec(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic wr_init(input logic v);
    init_we = 1'b1; init_wdata = v;
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic pulse_boff();
    boff_enter = 1'b1;
    @(negedge clk);
    boff_enter = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1", "reset init_bit", int'(init_bit), 1);
    chk("R1", "reset node_active", int'(node_active), 0);
    chk("R1", "reset tx_recessive", int'(tx_recessive), 1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post-reset bus_off", int'(bus_off), 0);
    chk("R1", "post-reset frame_abort", int'(frame_abort), 0);

    // R4: broken run and untimed cycles do not count
    wr_init(1'b0);
    send_rec(5);
    send_bit(1'b0);
    send_rec(10);
    chk("R4", "run broken by dominant", int'(node_active), 0);
    // R3: 11th consecutive recessive bit joins
    send_bit(1'b1);
    chk("R3", "joined after 11", int'(node_active), 1);

    // R2: init set while active
    wr_init(1'b1);
    chk("R2", "frame_abort pulse", int'(frame_abort), 1);
    chk("R2", "tx_recessive forced", int'(tx_recessive), 1);
    @(negedge clk);
    chk("R2", "node_active dropped", int'(node_active), 0);
    chk("R2", "abort is one cycle", int'(frame_abort), 0);

    // R5: bus-off entry
    wr_init(1'b0);
    send_rec(11);
    pulse_boff();
    chk("R5", "bus_off set", int'(bus_off), 1);
    chk("R5", "node_active cleared", int'(node_active), 0);

    // R7 / R9: init toggled mid-recovery, ends with init 0
    send_rec(64 * 11);
    wr_init(1'b1);
    send_rec(30 * 11);
    wr_init(1'b0);
    send_rec(33 * 11 + 10);
    chk("R7", "still bus-off after 127 runs", int'(bus_off), 1);
    send_bit(1'b1);
    chk("R6", "bus_off clears on 128th run", int'(bus_off), 0);
    chk("R9", "active at recovery end", int'(node_active), 1);

    // R8: recovery ends with init 1
    pulse_boff();
    wr_init(1'b1);
    send_rec(128 * 11);
    chk("R8", "bus_off left", int'(bus_off), 0);
    chk("R8", "stays inactive", int'(node_active), 0);
    wr_init(1'b0);
    send_rec(10);
    chk("R8", "needs fresh run", int'(node_active), 0);
    send_bit(1'b1);
    chk("R8", "joins after fresh run", int'(node_active), 1);

    // R10: suspend waits for idle, keeps init_bit
    susp_en = 1'b1; susp_req = 1'b1; bus_idle = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "no effect while busy", int'(node_active), 1);
    bus_idle = 1'b1;
    @(negedge clk);
    chk("R10", "suspend aborts frame", int'(frame_abort), 1);
    @(negedge clk);
    chk("R10", "suspend deactivates", int'(node_active), 0);
    chk("R10", "init_bit unchanged", int'(init_bit), 0);
    susp_req = 1'b0; bus_idle = 1'b0;
    @(negedge clk);
    send_rec(10);
    chk("R10", "rejoin needs run", int'(node_active), 0);
    send_bit(1'b1);
    chk("R10", "rejoined", int'(node_active), 1);

    // R11: suspend disabled
    susp_en = 1'b0; susp_req = 1'b1; bus_idle = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11", "still active", int'(node_active), 1);
    chk("R11", "tx not forced", int'(tx_recessive), 0);
    susp_req = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule